// File: doc/BRIEF.md
# Paged Edge-Interrupt Digital I/O Controller

This block gives a host 48 digital I/O lines, arranged as six byte-wide ports, over a plain byte bus. The bus has a 4-bit address, a write strobe and a read strobe. Writing a port offset loads that port's output latch, which drives the outward pin vector. Reading a port offset returns the pin levels that the block has sampled.

The lowest three ports can also raise edge interrupts. Each interrupt line has an enable bit, a polarity bit and a pending bit. These three per-port register sets share one group of three addresses. A page register picks which of the three sets those addresses reach. The pins pass through a two-stage synchroniser, and an edge detector works on the synchronised levels. A line that sees its selected edge while enabled latches a pending bit. The OR of all pending bits drives a single active-high interrupt output. Software acknowledges an interrupt by clearing the line's enable bit and then setting it again.

Top module: `pgio_ctrl`

## Requirements
- R1: A write to offset p (0 to 5) loads the output latch of port p, which drives `pin_out[8p+7:8p]` from the clock edge that takes the write.
- R2: A read of offset p (0 to 5) returns `pin_in[8p+7:8p]` as sampled through a two-flop synchroniser. A level held for three clocks is returned.
- R3: Offset 7 is a readable and writable page register. The value 0x80 steers offsets 8, 9 and 10 to the enable bytes of ports 0, 1 and 2. The value 0x40 steers them to the polarity bytes, and 0xC0 steers them to the pending bytes. With any other page value, offsets 8 to 10 read 0 and ignore writes.
- R4: A polarity bit of 1 makes its line detect a rising edge. A polarity bit of 0 makes it detect a falling edge.
- R5: A pending bit sets on its line's selected edge only while that line's enable bit is 1, and it stays set until cleared. Lines of ports 3 to 5 never interrupt.
- R6: Offset 6 is read-only. Bit p (p = 0 to 2) is 1 while port p has any pending bit, and bits 7 to 3 read 0.
- R7: Writing 0 to an enable bit clears that line's pending bit in the same edge. Writing the bit back to 1 does not raise it again without a new edge.
- R8: Reset, which is synchronous and active high, clears the port latches, the page register, and all enable, polarity and pending bits. The interrupt output is low after reset.
- R9: With page 0xC0, a read of offset 8+p returns port p's eight pending bits, and writes to offsets 8 to 10 change nothing.
- R10: `irq` is high exactly while at least one pending bit is set. It follows a pending bit with no added delay.
- R11: Reads of offsets 11 to 15 return 0, and so does any offset while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid while it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from registers) |
| pin_in | input | 48 | Pin levels, asynchronous to clk |
| pin_out | output | 48 | Output latch values, port p on bits 8p+7:8p |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A wrong enable, polarity or pending bit stays hidden until an edge reaches its line. The bench therefore drives edges of both directions on enabled and disabled lines. It then watches `irq` three clocks after each pin change, two for the synchroniser and one for the pending flop. A decode fault in the page logic shows up right away, because the bench reads back the register that was written and the registers that a wrong page would have touched. A lost or sticky pending bit shows on offset 6 and on `irq` in the cycle after an acknowledge write.

// File: rtl/pgio_pkg.sv
package pgio_pkg;

    localparam int BYTE_W      = 8;
    localparam int OFF_SUMMARY = 6;
    localparam int OFF_PAGE    = 7;
    localparam int OFF_BANK0   = 8;

    localparam logic [BYTE_W-1:0] PAGE_EN_CODE  = 8'h80;
    localparam logic [BYTE_W-1:0] PAGE_POL_CODE = 8'h40;
    localparam logic [BYTE_W-1:0] PAGE_ID_CODE  = 8'hC0;

    typedef enum logic [1:0] {
        BANK_OFF,
        BANK_EN,
        BANK_POL,
        BANK_ID
    } bank_e;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [3:0]          addr;
        logic [BYTE_W-1:0]   data;
    } bus_req_t;

    function automatic bank_e decode_page(input logic [BYTE_W-1:0] v);
        case (v)
            PAGE_EN_CODE:  return BANK_EN;
            PAGE_POL_CODE: return BANK_POL;
            PAGE_ID_CODE:  return BANK_ID;
            default:       return BANK_OFF;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] edge_hits(
        input logic [BYTE_W-1:0] now_lvl,
        input logic [BYTE_W-1:0] old_lvl,
        input logic [BYTE_W-1:0] rising_sel
    );
        return (rising_sel & now_lvl & ~old_lvl) | (~rising_sel & ~now_lvl & old_lvl);
    endfunction

endpackage

// File: rtl/pgio_sync.sv
module pgio_sync #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/pgio_latches.sv
module pgio_latches
    import pgio_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  bus_req_t                      req,
    output logic [NUM_PORTS*BYTE_W-1:0]   latch_out,
    output logic [BYTE_W-1:0]             page_q
);
    logic [NUM_PORTS-1:0][BYTE_W-1:0] port_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                port_q[p] <= '0;
            end else if (req.wr && req.addr == 4'(p)) begin
                port_q[p] <= req.data;
            end
        end
        assign latch_out[p*BYTE_W +: BYTE_W] = port_q[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else if (req.wr && req.addr == 4'(OFF_PAGE)) begin
            page_q <= req.data;
        end
    end
endmodule

// File: rtl/pgio_edge_port.sv
module pgio_edge_port
    import pgio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] lvl_sync,
    input  logic              en_wr,
    input  logic              pol_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] en_q,
    output logic [BYTE_W-1:0] pol_q,
    output logic [BYTE_W-1:0] pend_q
);
    logic [BYTE_W-1:0] prev_q;
    logic [BYTE_W-1:0] hit;
    logic [BYTE_W-1:0] armed;
    logic [BYTE_W-1:0] pend_d;

    always_comb begin
        hit    = edge_hits(lvl_sync, prev_q, pol_q);
        armed  = pend_q | (hit & en_q);
        pend_d = en_wr ? (armed & wdata) : armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lvl_sync;
            pend_q <= pend_d;
            if (en_wr)  en_q  <= wdata;
            if (pol_wr) pol_q <= wdata;
        end
    end
endmodule

// File: rtl/pgio_ctrl.sv
module pgio_ctrl
    import pgio_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [3:0]                  bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [7:0]                  bus_wdata,
    output logic [7:0]                  bus_rdata,
    input  logic [NUM_PORTS*8-1:0]      pin_in,
    output logic [NUM_PORTS*8-1:0]      pin_out,
    output logic                        irq
);
    localparam int PINS     = NUM_PORTS * BYTE_W;
    localparam int IRQ_PINS = IRQ_PORTS * BYTE_W;

    bus_req_t              req;
    logic [PINS-1:0]       pin_sync;
    logic [BYTE_W-1:0]     page_q;
    bank_e                 bank;
    logic [IRQ_PINS-1:0]   en_all;
    logic [IRQ_PINS-1:0]   pol_all;
    logic [IRQ_PINS-1:0]   pend_all;
    logic [BYTE_W-1:0]     summary;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};

    pgio_sync #(.WIDTH(PINS)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    pgio_latches #(.NUM_PORTS(NUM_PORTS)) latch_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .latch_out (pin_out),
        .page_q    (page_q)
    );

    assign bank = decode_page(page_q);

    for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_irq
        logic sel;
        assign sel = req.wr && (req.addr == 4'(OFF_BANK0 + p));
        pgio_edge_port edge_i (
            .clk      (clk),
            .rst      (rst),
            .lvl_sync (pin_sync[p*BYTE_W +: BYTE_W]),
            .en_wr    (sel && bank == BANK_EN),
            .pol_wr   (sel && bank == BANK_POL),
            .wdata    (req.data),
            .en_q     (en_all[p*BYTE_W +: BYTE_W]),
            .pol_q    (pol_all[p*BYTE_W +: BYTE_W]),
            .pend_q   (pend_all[p*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        summary = '0;
        for (int p = 0; p < IRQ_PORTS; p++) begin
            summary[p] = |pend_all[p*BYTE_W +: BYTE_W];
        end
    end

    assign irq = |pend_all;

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (req.addr == 4'(p)) bus_rdata = pin_sync[p*BYTE_W +: BYTE_W];
            end
            if (req.addr == 4'(OFF_SUMMARY)) bus_rdata = summary;
            if (req.addr == 4'(OFF_PAGE))    bus_rdata = page_q;
            for (int p = 0; p < IRQ_PORTS; p++) begin
                if (req.addr == 4'(OFF_BANK0 + p)) begin
                    case (bank)
                        BANK_EN:  bus_rdata = en_all[p*BYTE_W +: BYTE_W];
                        BANK_POL: bus_rdata = pol_all[p*BYTE_W +: BYTE_W];
                        BANK_ID:  bus_rdata = pend_all[p*BYTE_W +: BYTE_W];
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pgio_ctrl_chk.sv
module pgio_ctrl_chk #(
    parameter int PINS      = 48,
    parameter int IRQ_PORTS = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   bus_wr,
    input logic [3:0]             bus_addr,
    input logic [7:0]             page_q,
    input logic [PINS-1:0]        pin_out,
    input logic                   irq,
    input logic [IRQ_PORTS*8-1:0] en_all,
    input logic [IRQ_PORTS*8-1:0] pol_all,
    input logic [IRQ_PORTS*8-1:0] pend_all
);
    logic locked_wr;
    assign locked_wr = bus_wr && (page_q == 8'hC0) &&
                       (bus_addr >= 4'd8) && (bus_addr < 4'(8 + IRQ_PORTS));

    // R7: no pending bit survives without its enable bit
    a_r7_pend_needs_en: assert property (@(posedge clk) disable iff (rst)
        (pend_all & ~en_all) == '0);

    // R5: a newly set pending bit had its enable set in the prior cycle
    a_r5_new_pend_enabled: assert property (@(posedge clk) disable iff (rst)
        (pend_all & ~$past(pend_all) & ~$past(en_all)) == '0);

    // R8: leaving reset, the block is quiet and latches are clear
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq && pin_out == '0 && pend_all == '0));

    // R9: writes in the pending page leave the configuration untouched
    a_r9_id_page_ro: assert property (@(posedge clk) disable iff (rst)
        locked_wr |=> ($stable(en_all) && $stable(pol_all)));

    // R10: interrupt rises only when some pending bit is set
    a_r10_irq_pending: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $countones(pend_all) > 0);
endmodule

bind pgio_ctrl pgio_ctrl_chk #(.PINS(PINS), .IRQ_PORTS(IRQ_PORTS)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .page_q   (page_q),
    .pin_out  (pin_out),
    .irq      (irq),
    .en_all   (en_all),
    .pol_all  (pol_all),
    .pend_all (pend_all)
);

// File: tb/pgio_ctrl_tb.sv
module pgio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_out;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pgio_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    // Monitor: compares each read result against the scoreboard queue
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s read addr %0d: got %02h expected %02h", t, bus_addr, bus_rdata, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_bit(input logic got, input logic e, input string t);
        @(negedge clk);
        checks++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", t, got, e);
        end
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R8: reset state
        chk_bit(irq, 1'b0, "R8 irq after reset");
        chk_bit(pin_out == '0, 1'b1, "R8 latches after reset");
        rd(4'd7, 8'h00, "R8");
        // R11: unused offsets and no-strobe behaviour
        rd(4'd12, 8'h00, "R11");
        rd(4'd15, 8'h00, "R11");
        // R1: port latch drives pins
        wr(4'd3, 8'hA5);
        chk_bit(pin_out[31:24] == 8'hA5, 1'b1, "R1 port3 latch");
        wr(4'd0, 8'h5A);
        chk_bit(pin_out[7:0] == 8'h5A, 1'b1, "R1 port0 latch");
        // R2: pin readback after synchroniser
        pin_in[39:32] = 8'h3C;
        idle(3);
        rd(4'd4, 8'h3C, "R2");
        // R3: page programming
        wr(4'd7, 8'h80);
        rd(4'd7, 8'h80, "R3");
        wr(4'd8, 8'h01);
        wr(4'd9, 8'h08);
        wr(4'd7, 8'h40);
        wr(4'd8, 8'h01);
        rd(4'd8, 8'h01, "R3 polarity page");
        rd(4'd9, 8'h00, "R3 polarity page");
        wr(4'd7, 8'h80);
        rd(4'd8, 8'h01, "R3 enable page");
        // R4/R5: rising edge on port0 bit0
        pin_in[0] = 1'b1;
        idle(3);
        chk_bit(irq, 1'b1, "R4 rising edge sets irq");
        rd(4'd6, 8'h01, "R6");
        // R4: falling edge on a rising line does nothing new; R7 ack
        wr(4'd8, 8'h00);
        chk_bit(irq, 1'b0, "R7 clear by disable");
        wr(4'd8, 8'h01);
        idle(2);
        chk_bit(irq, 1'b0, "R7 re-enable does not re-raise");
        pin_in[0] = 1'b0;
        idle(4);
        chk_bit(irq, 1'b0, "R4 falling ignored on rising line");
        // R4: falling line port1 bit3 ignores rising edge
        pin_in[11] = 1'b1;
        idle(4);
        chk_bit(irq, 1'b0, "R4 rising ignored on falling line");
        pin_in[11] = 1'b0;
        idle(3);
        chk_bit(irq, 1'b1, "R10 falling edge raises irq");
        rd(4'd6, 8'h02, "R6");
        // R9: pending page readback and write lock
        wr(4'd7, 8'hC0);
        rd(4'd9, 8'h08, "R9");
        wr(4'd9, 8'h00);
        rd(4'd9, 8'h08, "R9 write ignored");
        chk_bit(irq, 1'b1, "R9 irq held");
        // R5: disabled line and non-interrupt port
        pin_in[16] = 1'b1;
        pin_in[47:40] = 8'h81;
        idle(4);
        pin_in[16] = 1'b0;
        pin_in[47:40] = 8'h00;
        idle(4);
        rd(4'd10, 8'h00, "R5 disabled line");
        rd(4'd6, 8'h02, "R5 summary unchanged");
        pin_in[47:40] = 8'h81;
        idle(3);
        rd(4'd5, 8'h81, "R2 port5");
        // R3: unknown page reads 0 and drops writes
        wr(4'd7, 8'h12);
        rd(4'd8, 8'h00, "R3 closed page");
        wr(4'd8, 8'hFF);
        wr(4'd7, 8'h80);
        rd(4'd8, 8'h01, "R3 closed page write dropped");
        // R7: ack port1 line, irq drops
        wr(4'd9, 8'h00);
        chk_bit(irq, 1'b0, "R7 ack port1");
        rd(4'd6, 8'h00, "R6 summary cleared");
        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule